// File: doc/BRIEF.md
# Half-Word Write-Masked GPIO Port

This block is a 32-pin general-purpose I/O port controlled over a simple memory-mapped bus. Software drives an output-value register and an output-enable register, and reads back the synchronized state of the external pins. Each 32-pin logical register spans two consecutive bus words. The first word holds pins 0 to 15 and the word four bytes above it holds pins 16 to 31.

Every write to a control word carries 16 data bits in its low half and 16 per-bit write enables in its high half. Software can therefore set or clear any single pin with one write and needs no read-modify-write sequence. A read-only identifier word lets software detect the port variant. Pad drivers, multiplexing and interrupt logic belong to neighbouring blocks.

The bus is a single-cycle write strobe with a byte address. Read data is combinational from the address. External pin inputs pass through a synchronizer before they can be read.

Top module: `gpio_hw_port`

## Requirements
- R1: In a write to a control word, bits 31:16 enable bits 15:0. An enabled data bit takes the written value on the next clock edge. Every other bit keeps its value.
- R2: For both control registers, pins 0-15 are at the register's base byte address and pins 16-31 are at base+4. Output value is at base 0x00 and output enable is at base 0x08.
- R3: Reading any control word (0x00, 0x04, 0x08, 0x0C) returns its 16 pins in bits 15:0, with the lowest pin at bit 0, and zero in bits 31:16.
- R4: `pin_out` shows the output-value register and `pin_oe` shows the output-enable register, pin n at bit n. An enable bit of 1 makes that pin an output and 0 makes it an input.
- R5: A read at 0x70 returns all 32 external pins with pin n at bit n. It shows the value `pin_in` had two rising clock edges earlier, through two synchronizer flops.
- R6: A read at 0x78 returns the constant identifier 0x01000C2B.
- R7: While `rst_n` is low at a clock edge, the output-value register, the output-enable register and the synchronizer are cleared. All pins therefore come up as inputs driving 0.
- R8: A write to 0x70, 0x78 or any unmapped address changes no register. A read of an unmapped address returns zero.
- R9: A write whose enable half is all zero leaves the addressed register unchanged, whatever its data half holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data: enables in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous external pin levels |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = output |

## Verification
The bench uses the default parameters: a 16-bit half word, two synchronizer stages and the 0x01000C2B identifier. These values fix the address map exactly at 0x00, 0x04, 0x08, 0x0C, 0x70 and 0x78, so every mapped word and the gaps around it can be written and read. The two-stage synchronizer gives an input latency the reference model can follow edge by edge. Partial masks, empty masks, upper-half writes and writes to read-only words are each compared against the model on every clock.

// File: rtl/gpio_hw_pkg.sv
// Package: shared constants for the half-word write-masked GPIO port.
// Assumes a 32-pin port split into two 16-bit halves.
package gpio_hw_pkg;
    localparam int HALF_W      = 16;
    localparam int NUM_HALVES  = 2;
    localparam int PORT_W      = HALF_W * NUM_HALVES;
    localparam int BUS_W       = 32;
    localparam int ADDR_W      = 8;
    localparam int WORD_BYTES  = 4;

    localparam logic [ADDR_W-1:0] OFS_DOUT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EXT  = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_VER  = 8'h78;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DOUT = 2'd1,
        SEL_DIR  = 2'd2
    } ctl_sel_e;
endpackage

// File: rtl/gpio_wmask_half.sv
// Module: one half-word register with a per-bit write enable.
// Writes take the enable mask from the upper half of the data word.
// Assumes the data word is exactly twice the register width.
module gpio_wmask_half #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_stb,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);
    logic [W-1:0] en;
    logic [W-1:0] d;

    // Split the write word into its enable and data halves.
    always_comb begin
        en = wdata[2*W-1:W];
        d  = wdata[W-1:0];
    end

    // Update only the enabled bits on a write. Clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_stb) begin
            q <= (q & ~en) | (d & en);
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-flop synchronizer for the external pin bus.
// Assumes STAGES >= 1. The output lags the input by STAGES edges.
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    // Shift the pin levels through the flop chain. Clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    // Present the last stage.
    always_comb q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_rd_mux.sv
// Module: read-data selection for the GPIO port.
// Control words return a zero-extended half. Unmapped addresses read 0.
module gpio_rd_mux
    import gpio_hw_pkg::*;
#(
    parameter logic [BUS_W-1:0] ID_VALUE = 32'h01000C2B
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] dout,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] ext,
    output logic [BUS_W-1:0]  rdata
);
    localparam int PAD_W = BUS_W - HALF_W;

    // Decode the address to one of the readable words.
    always_comb begin
        rdata = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (addr == OFS_DOUT + ADDR_W'(h * WORD_BYTES))
                rdata = {{PAD_W{1'b0}}, dout[h*HALF_W +: HALF_W]};
            if (addr == OFS_DIR + ADDR_W'(h * WORD_BYTES))
                rdata = {{PAD_W{1'b0}}, dir[h*HALF_W +: HALF_W]};
        end
        if (addr == OFS_EXT) rdata = ext;
        if (addr == OFS_VER) rdata = ID_VALUE;
    end
endmodule

// File: rtl/gpio_hw_port.sv
// Module: top of the 32-pin GPIO port with half-word masked writes.
// Output-value and output-enable registers each span two bus words.
// External pins are synchronized before they are read.
// Synchronous active-low reset. Reads are combinational.
module gpio_hw_port
    import gpio_hw_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [31:0]      ID_VALUE    = 32'h01000C2B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe
);
    logic [NUM_HALVES-1:0] wr_dout;
    logic [NUM_HALVES-1:0] wr_dir;
    logic [PORT_W-1:0]     dout_q;
    logic [PORT_W-1:0]     dir_q;
    logic [PORT_W-1:0]     ext_q;

    // Write strobes, one per half of each control register.
    always_comb begin
        for (int h = 0; h < NUM_HALVES; h++) begin
            wr_dout[h] = bus_wr && (bus_addr == OFS_DOUT + ADDR_W'(h * WORD_BYTES));
            wr_dir[h]  = bus_wr && (bus_addr == OFS_DIR  + ADDR_W'(h * WORD_BYTES));
        end
    end

    // One masked half register per half, for both control registers.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        gpio_wmask_half #(.W(HALF_W)) u_dout (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (wr_dout[h]),
            .wdata  (bus_wdata),
            .q      (dout_q[h*HALF_W +: HALF_W])
        );
        gpio_wmask_half #(.W(HALF_W)) u_dir (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (wr_dir[h]),
            .wdata  (bus_wdata),
            .q      (dir_q[h*HALF_W +: HALF_W])
        );
    end

    gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (ext_q)
    );

    gpio_rd_mux #(.ID_VALUE(ID_VALUE)) u_rd (
        .addr  (bus_addr),
        .dout  (dout_q),
        .dir   (dir_q),
        .ext   (ext_q),
        .rdata (bus_rdata)
    );

    // Drive the pad-side outputs from the registers.
    always_comb begin
        pin_out = dout_q;
        pin_oe  = dir_q;
    end
endmodule

// File: rtl/gpio_hw_port_chk.sv
// Module: property checker for gpio_hw_port, attached with bind.
// Assumes the default two-stage synchronizer and the fixed address map.
module gpio_hw_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] pin_in,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe
);
    logic [1:0] since_rst;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: disabled bits of the low output word keep their value.
    assert_mask_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=>
        (((pin_out[15:0] ^ $past(pin_out[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

    // R2: a write to the upper word leaves pins 0-15 alone.
    assert_hi_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h04) |=> $stable(pin_out[15:0]));

    // R3: the upper half of every control word reads as zero.
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[7:4] == 4'h0 && bus_addr[1:0] == 2'b00) |-> (bus_rdata[31:16] == 16'h0));

    // R4: an enable write changes only the enabled bits of pin_oe.
    assert_dir_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h08) |=>
        (((pin_oe[15:0] ^ $past(pin_oe[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

    // R5: the pin word lags pin_in by two edges.
    assert_sync_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && bus_addr == 8'h70) |-> (bus_rdata == $past(pin_in, 2)));

    // R6: the identifier word is constant.
    assert_version_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h78) |-> (bus_rdata == 32'h01000C2B));

    // R7: reset clears both control registers.
    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (pin_out == 32'h0 && pin_oe == 32'h0));

    // R8: a write outside the control words changes nothing.
    assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[7:4] != 4'h0) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_hw_port gpio_hw_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpio_hw_port.sv
// Bench: behavioural reference model compared against the port on every clock.
module test_gpio_hw_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = 32'h0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R7";

    // Reference state.
    logic [31:0] m_dout = 32'h0;
    logic [31:0] m_dir  = 32'h0;
    logic [31:0] m_s1   = 32'h0;
    logic [31:0] m_s2   = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_hw_port i_gpio_hw_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w);
        return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout <= 32'h0; m_dir <= 32'h0; m_s1 <= 32'h0; m_s2 <= 32'h0;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_dout[15:0]  <= merge(m_dout[15:0],  bus_wdata);
                    8'h04: m_dout[31:16] <= merge(m_dout[31:16], bus_wdata);
                    8'h08: m_dir[15:0]   <= merge(m_dir[15:0],   bus_wdata);
                    8'h0C: m_dir[31:16]  <= merge(m_dir[31:16],  bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_dout[15:0]};
            8'h04: return {16'h0, m_dout[31:16]};
            8'h08: return {16'h0, m_dir[15:0]};
            8'h0C: return {16'h0, m_dir[31:16]};
            8'h70: return m_s2;
            8'h78: return 32'h01000C2B;
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic step(string req, logic wr, logic [7:0] a, logic [31:0] wd, logic [31:0] pins);
        @(negedge clk);
        cmp("pin_out", pin_out, m_dout);
        cmp("pin_oe", pin_oe, m_dir);
        cmp("rdata", bus_rdata, exp_rd(bus_addr));
        cur_req = req;
        bus_wr = wr; bus_addr = a; bus_wdata = wd; pin_in = pins;
    endtask

    task automatic rd(string req, logic [7:0] a);
        step(req, 1'b0, a, 32'hDEAD_BEEF, pin_in);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R7: reset state.
        step("R7", 0, 8'h00, 0, 32'h0);
        step("R7", 0, 8'h08, 0, 32'h0);
        step("R7", 0, 8'h00, 0, 32'h0);
        rst_n = 1'b1;
        rd("R7", 8'h00); rd("R7", 8'h0C);
        // R1: full and partial masks on the low output word.
        step("R1", 1, 8'h00, 32'hFFFF_A5A5, 32'h0);
        rd("R1", 8'h00);
        step("R1", 1, 8'h00, 32'h00F0_0000, 32'h0);
        rd("R1", 8'h00);
        step("R1", 1, 8'h00, 32'h8001_FFFF, 32'h0);
        rd("R1", 8'h00);
        // R9: empty mask.
        step("R9", 1, 8'h00, 32'h0000_FFFF, 32'h0);
        rd("R9", 8'h00);
        step("R9", 1, 8'h08, 32'h0000_1234, 32'h0);
        rd("R9", 8'h08);
        // R2: upper word holds pins 16-31.
        step("R2", 1, 8'h04, 32'hFFFF_C3C3, 32'h0);
        rd("R2", 8'h04); rd("R2", 8'h00);
        step("R2", 1, 8'h04, 32'h0100_0000, 32'h0);
        rd("R2", 8'h04);
        // R4: output enables in both halves.
        step("R4", 1, 8'h08, 32'hFFFF_00FF, 32'h0);
        step("R4", 1, 8'h0C, 32'hF000_F000, 32'h0);
        step("R4", 1, 8'h08, 32'h0003_0002, 32'h0);
        rd("R4", 8'h08);
        // R3: every control word reads zero-extended.
        rd("R3", 8'h00); rd("R3", 8'h04); rd("R3", 8'h08); rd("R3", 8'h0C);
        // R5: pin patterns through the synchronizer.
        step("R5", 0, 8'h70, 0, 32'h8000_0001);
        step("R5", 0, 8'h70, 0, 32'h5A5A_F00F);
        step("R5", 0, 8'h70, 0, 32'hFFFF_FFFF);
        step("R5", 0, 8'h70, 0, 32'h0000_0000);
        rd("R5", 8'h70); rd("R5", 8'h70); rd("R5", 8'h70);
        // R6: identifier.
        rd("R6", 8'h78); rd("R6", 8'h78);
        // R8: writes to read-only and unmapped words, unmapped reads.
        step("R8", 1, 8'h70, 32'hFFFF_FFFF, 32'h1234_5678);
        step("R8", 1, 8'h78, 32'hFFFF_FFFF, 32'h1234_5678);
        step("R8", 1, 8'h10, 32'hFFFF_FFFF, 32'h1234_5678);
        step("R8", 1, 8'h02, 32'hFFFF_FFFF, 32'h1234_5678);
        rd("R8", 8'h40); rd("R8", 8'h00); rd("R8", 8'h0C); rd("R8", 8'h78);
        // R7: reset again after activity.
        step("R7", 0, 8'h00, 0, 32'hFFFF_0000);
        rst_n = 1'b0;
        rd("R7", 8'h70); rd("R7", 8'h08);
        rst_n = 1'b1;
        rd("R7", 8'h70); rd("R7", 8'h70); rd("R7", 8'h70);
        @(negedge clk);
        cmp("pin_out", pin_out, m_dout);
        cmp("rdata", bus_rdata, exp_rd(bus_addr));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule